// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block sits between a local token source and sink on one side and a full-duplex point-to-point link transmitter/receiver on the other. A token is nine bits wide: a control flag and an 8-bit code. The block paces outgoing traffic with a send-credit counter. It tracks how much receive buffer it has promised the far end with an issued-credit counter. Credit grants and link resets travel in-band as reserved control tokens. The block inserts these tokens on the transmit path and strips them from the receive path, so the sink only ever sees ordinary traffic.

Link bring-up is run by a small state machine with four states:
- `LNK_OFF`: the link is disabled.
- `LNK_ARMED`: the link is enabled and no reset token has been sent yet.
- `LNK_HELLO`: a reset token is being presented to the link.
- `LNK_RUN`: normal traffic.

The transitions are:
- OFF→ARMED when `link_en` is high.
- ARMED→HELLO and RUN→HELLO when `hello_req` is sampled high.
- HELLO→RUN when the link accepts the reset token.
- Any state→OFF whenever `link_en` is low.

On the receive side, a reset token from the far end clears the issued-credit counter and permits credit grants. From then on, the block tops up the far end whenever the outstanding promise falls below a low mark.

Reserved control codes (control flag set):
- 0xE0: reset (hello).
- 0xE1: grant 8 credits.
- 0xE2: grant 16 credits.
- 0xE3: grant 64 credits.

Top module: `lfc_link_ctrl`

## Requirements
- R1: While `link_en` is low, the block transmits nothing from the cycle after it is sampled low. It also holds `src_ready` low, clears both credit counters and the peer-ready flag, and ignores every received token.
- R2: When `hello_req` is sampled high with the link enabled (state ARMED or RUN), the next cycle presents the reset token (ctrl=1, code 0xE0) on the transmit port. The token is held until `tx_ready`. A request made while the link is disabled has no effect.
- R3: The cycle in which the reset token is accepted sets the send-credit counter to zero. A credit grant received in that same cycle is still counted.
- R4: Source tokens are passed to the link unchanged, only in state RUN and only while send credit is nonzero. Each accepted token decrements the credit by one. A grant received in the same cycle as a send nets against it.
- R5: A received control token with code 0xE1, 0xE2 or 0xE3 adds 8, 16 or 64 to the send-credit counter, saturating at its maximum.
- R6: A received reset token (ctrl=1, 0xE0) clears the issued-credit counter and enables credit grants back to the far end.
- R7: When grants are enabled and fewer than 8 credits are outstanding, the block sends one grant. It picks the largest of 64 (0xE3), 16 (0xE2) or 8 (0xE1) that fits in the free receive-buffer space minus the outstanding credits. The outstanding count rises by that amount when the grant is accepted.
- R8: The receive buffer holds 64 tokens. Outstanding credits never exceed its free space. Each received non-reserved token decrements the outstanding count, and such a token arriving with no credits outstanding is discarded.
- R9: Reset and grant tokens are never delivered to the sink. All other received tokens reach the sink in arrival order.
- R10: Transmit priority is the reset token first, then a credit grant, then a source token. `src_ready` is low while a higher-priority token is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en | input | 1 | Link enable |
| hello_req | input | 1 | Request to send a reset token |
| src_valid | input | 1 | Source token valid |
| src_ready | output | 1 | Source token accepted |
| src_ctrl | input | 1 | Source token control flag |
| src_data | input | 8 | Source token code |
| tx_valid | output | 1 | Token presented to the link |
| tx_ready | input | 1 | Link accepts the presented token |
| tx_ctrl | output | 1 | Transmit control flag |
| tx_data | output | 8 | Transmit code |
| rx_valid | input | 1 | Received token valid |
| rx_ctrl | input | 1 | Received control flag |
| rx_data | input | 8 | Received code |
| snk_valid | output | 1 | Sink token valid |
| snk_ready | input | 1 | Sink takes the token |
| snk_ctrl | output | 1 | Sink token control flag |
| snk_data | output | 8 | Sink token code |

## Verification
Two pairs of events can land in the same cycle and are both driven deliberately.

The first pair is the reset token leaving and a credit grant arriving. The bench holds `tx_ready` low while the reset token waits. It then raises `tx_ready` in the same cycle that it presents a 16-credit grant, and counts how many source tokens are accepted afterwards; exactly 16 is expected.

The second pair is a source token being accepted and a grant arriving. With one credit left, the bench offers a token and an 8-credit grant together. It then expects exactly 8 further acceptances, proving the counter moved by 8−1 from 1.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;
    localparam int GRANT_W = 7;

    localparam logic [7:0] CODE_HELLO = 8'hE0;
    localparam logic [7:0] CODE_GR_S  = 8'hE1;
    localparam logic [7:0] CODE_GR_M  = 8'hE2;
    localparam logic [7:0] CODE_GR_L  = 8'hE3;

    localparam int GRANT_S = 8;
    localparam int GRANT_M = 16;
    localparam int GRANT_L = 64;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] code;
    } token_t;

    typedef enum logic [1:0] {
        LNK_OFF,
        LNK_ARMED,
        LNK_HELLO,
        LNK_RUN
    } lnk_state_e;

    // Credit amount carried by a control code, zero for anything else.
    function automatic logic [GRANT_W-1:0] grant_size(input logic [7:0] code);
        case (code)
            CODE_GR_S: return GRANT_W'(GRANT_S);
            CODE_GR_M: return GRANT_W'(GRANT_M);
            CODE_GR_L: return GRANT_W'(GRANT_L);
            default:   return '0;
        endcase
    endfunction

    function automatic logic is_reserved(input logic ctrl, input logic [7:0] code);
        return ctrl && (code == CODE_HELLO || code == CODE_GR_S ||
                        code == CODE_GR_M  || code == CODE_GR_L);
    endfunction
endpackage

// File: rtl/lfc_rx_fifo.sv
`timescale 1ns/1ps
module lfc_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] free
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign free      = CW'(DEPTH) - count;

    // R8: the credit discipline must never let the buffer overflow
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
endmodule

// File: rtl/lfc_tx_credit.sv
`timescale 1ns/1ps
module lfc_tx_credit
    import lfc_pkg::*;
#(
    parameter int CRED_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               hello_sent,
    input  logic [GRANT_W-1:0] grant_amt,
    input  logic               spend,
    output logic               credit_nz
);
    localparam int SW = CRED_W + 1;

    logic [CRED_W-1:0] credit, credit_nxt;
    logic [SW-1:0]     wide;

    always_comb begin
        wide = {1'b0, (hello_sent ? {CRED_W{1'b0}} : credit)}
             + SW'(grant_amt) - SW'(spend);
        if (clear)
            credit_nxt = '0;
        else if (wide[CRED_W])
            credit_nxt = '1;
        else
            credit_nxt = wide[CRED_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) credit <= '0;
        else        credit <= credit_nxt;
    end

    assign credit_nz = (credit != '0);

    // R4: nothing is spent from an empty counter
    p_no_dry_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (credit == '0) |-> !spend);
    // R4: a lone send costs exactly one credit
    p_spend_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spend && grant_amt == '0 && !hello_sent && !clear)
        |=> credit == $past(credit) - 1'b1);
    // R3: an accepted reset token leaves only the same-cycle grant
    p_hello_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hello_sent && !clear) |=> credit == CRED_W'($past(grant_amt)));
    // R5: an unsaturated grant adds its amount
    p_grant_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_amt != '0 && !spend && !hello_sent && !clear &&
         ({1'b0, credit} + SW'(grant_amt) <= {1'b0, {CRED_W{1'b1}}}))
        |=> credit == $past(credit) + CRED_W'($past(grant_amt)));
endmodule

// File: rtl/lfc_rx_issue.sv
`timescale 1ns/1ps
module lfc_rx_issue
    import lfc_pkg::*;
#(
    parameter int CW       = 7,
    parameter int LOW_MARK = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               peer_hello,
    input  logic               rx_push,
    input  logic [CW-1:0]      free,
    input  logic               grant_taken,
    output logic               grant_req,
    output logic [7:0]         grant_code,
    output logic [GRANT_W-1:0] grant_amt,
    output logic               issue_ok
);
    logic [CW-1:0] issued;
    logic [CW-1:0] avail;
    logic          peer_up;

    always_comb begin
        avail      = free - issued;
        grant_code = CODE_GR_S;
        grant_amt  = '0;
        if (32'(avail) >= GRANT_L) begin
            grant_code = CODE_GR_L;
            grant_amt  = GRANT_W'(GRANT_L);
        end else if (32'(avail) >= GRANT_M) begin
            grant_code = CODE_GR_M;
            grant_amt  = GRANT_W'(GRANT_M);
        end else if (32'(avail) >= GRANT_S) begin
            grant_amt  = GRANT_W'(GRANT_S);
        end
        grant_req = peer_up && (32'(issued) < LOW_MARK) && (grant_amt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued  <= '0;
            peer_up <= 1'b0;
        end else if (clear) begin
            issued  <= '0;
            peer_up <= 1'b0;
        end else begin
            issued <= (peer_hello ? {CW{1'b0}} : issued)
                    - CW'(rx_push)
                    + (grant_taken ? CW'(grant_amt) : {CW{1'b0}});
            if (peer_hello) peer_up <= 1'b1;
        end
    end

    assign issue_ok = (issued != '0);

    // R8: promises never exceed the buffer space actually free
    p_issued_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issued <= free);
    // R7: an accepted grant raises the outstanding count by its amount
    p_grant_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_taken && !rx_push && !peer_hello && !clear)
        |=> issued == $past(issued) + CW'($past(grant_amt)));
    // R6: a reset token from the far end restarts the count from zero
    p_peer_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_hello && !grant_taken && !clear) |=> issued == '0);
endmodule

// File: rtl/lfc_link_ctrl.sv
`timescale 1ns/1ps
module lfc_link_ctrl
    import lfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CRED_W     = 8,
    parameter int LOW_MARK   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_en,
    input  logic       hello_req,
    input  logic       src_valid,
    output logic       src_ready,
    input  logic       src_ctrl,
    input  logic [7:0] src_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       tx_ctrl,
    output logic [7:0] tx_data,
    input  logic       rx_valid,
    input  logic       rx_ctrl,
    input  logic [7:0] rx_data,
    output logic       snk_valid,
    input  logic       snk_ready,
    output logic       snk_ctrl,
    output logic [7:0] snk_data
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    lnk_state_e         state, state_nxt;
    logic               rx_live, rx_hello, rx_payload, rx_push;
    logic [GRANT_W-1:0] rx_grant;
    logic               issue_ok, grant_req;
    logic [7:0]         grant_code;
    logic [GRANT_W-1:0] grant_amt;
    logic [CW-1:0]      fifo_free;
    logic               credit_nz;
    logic               hello_sent, grant_go, grant_taken, src_go, spend;
    token_t             tx_tok, snk_tok;

    // ---------------- receive decode ----------------
    always_comb begin
        rx_live    = rx_valid && link_en;
        rx_hello   = rx_live && rx_ctrl && (rx_data == CODE_HELLO);
        rx_grant   = (rx_live && rx_ctrl) ? grant_size(rx_data) : '0;
        rx_payload = rx_live && !is_reserved(rx_ctrl, rx_data);
        rx_push    = rx_payload && issue_ok;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LNK_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            LNK_OFF:   if (link_en)   state_nxt = LNK_ARMED;
            LNK_ARMED: if (hello_req) state_nxt = LNK_HELLO;
            LNK_HELLO: if (tx_ready)  state_nxt = LNK_RUN;
            LNK_RUN:   if (hello_req) state_nxt = LNK_HELLO;
        endcase
        if (!link_en) state_nxt = LNK_OFF;
    end

    // ---------------- outputs / transmit arbitration ----------------
    always_comb begin
        hello_sent  = (state == LNK_HELLO) && tx_ready;
        grant_go    = ((state == LNK_ARMED) || (state == LNK_RUN)) && grant_req;
        src_go      = (state == LNK_RUN) && !grant_req && credit_nz;
        grant_taken = grant_go && tx_ready;
        src_ready   = src_go && tx_ready;
        spend       = src_valid && src_ready;
        tx_valid    = 1'b0;
        tx_tok      = '{ctrl: 1'b0, code: 8'h00};
        if (state == LNK_HELLO) begin
            tx_valid = 1'b1;
            tx_tok   = '{ctrl: 1'b1, code: CODE_HELLO};
        end else if (grant_go) begin
            tx_valid = 1'b1;
            tx_tok   = '{ctrl: 1'b1, code: grant_code};
        end else if (src_go && src_valid) begin
            tx_valid = 1'b1;
            tx_tok   = '{ctrl: src_ctrl, code: src_data};
        end
    end

    assign tx_ctrl  = tx_tok.ctrl;
    assign tx_data  = tx_tok.code;
    assign snk_ctrl = snk_tok.ctrl;
    assign snk_data = snk_tok.code;

    // ---------------- sub-blocks ----------------
    lfc_tx_credit #(.CRED_W(CRED_W)) u_tx_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!link_en),
        .hello_sent (hello_sent),
        .grant_amt  (rx_grant),
        .spend      (spend),
        .credit_nz  (credit_nz)
    );

    lfc_rx_issue #(.CW(CW), .LOW_MARK(LOW_MARK)) u_rx_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!link_en),
        .peer_hello  (rx_hello),
        .rx_push     (rx_push),
        .free        (fifo_free),
        .grant_taken (grant_taken),
        .grant_req   (grant_req),
        .grant_code  (grant_code),
        .grant_amt   (grant_amt),
        .issue_ok    (issue_ok)
    );

    lfc_rx_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(token_t))) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data ({rx_ctrl, rx_data}),
        .pop       (snk_valid && snk_ready),
        .out_valid (snk_valid),
        .out_data  (snk_tok),
        .free      (fifo_free)
    );

    // R1: a disabled link goes quiet on the next cycle
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!tx_valid && !src_ready));
    // R2: an accepted request puts the reset token on the wire
    p_hello_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hello_req && link_en && (state == LNK_ARMED || state == LNK_RUN))
        |=> (tx_valid && tx_ctrl && tx_data == CODE_HELLO));
    // R9: reserved tokens never reach the sink
    p_sink_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> !is_reserved(snk_ctrl, snk_data));
    // R10: a pending grant holds off source traffic
    p_grant_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_req && state == LNK_RUN) |-> !src_ready);
endmodule

// File: tb/lfc_link_ctrl_tb.sv
`timescale 1ns/1ps
module lfc_link_ctrl_tb_top;
    logic       clk = 1'b0, rst_n = 1'b0, link_en = 1'b0, hello_req = 1'b0;
    logic       src_valid = 1'b0, src_ctrl = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_ready;
    logic       tx_valid, tx_ctrl;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       rx_valid = 1'b0, rx_ctrl = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       snk_valid, snk_ctrl;
    logic [7:0] snk_data;
    logic       snk_ready = 1'b0;

    lfc_link_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .hello_req(hello_req),
        .src_valid(src_valid), .src_ready(src_ready), .src_ctrl(src_ctrl), .src_data(src_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ctrl(tx_ctrl), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ctrl(rx_ctrl), .rx_data(rx_data),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_ctrl(snk_ctrl), .snk_data(snk_data)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int n_chk = 0, n_fail = 0, n_cyc = 0;
    int hello_tx = 0, g_s = 0, g_m = 0, g_l = 0, hs_cnt = 0;
    logic [7:0] sink_seq = 8'h00, rx_seq = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input logic c, input logic [7:0] d);
        rx_valid = 1'b1; rx_ctrl = c; rx_data = d;
        cyc(1);
        rx_valid = 1'b0; rx_ctrl = 1'b0;
    endtask

    task automatic do_hello();
        hello_req = 1'b1;
        cyc(1);
        hello_req = 1'b0;
        cyc(3);
    endtask

    task automatic offer(input int n, output int got);
        int base = hs_cnt;
        for (int k = 0; k < n + 8; k++) begin
            src_valid = (hs_cnt - base) < n;
            src_data  = 8'(hs_cnt);
            cyc(1);
        end
        src_valid = 1'b0;
        got = hs_cnt - base;
    endtask

    // Monitor: samples at the falling edge, half a cycle from any input change.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready && tx_ctrl) begin
                case (tx_data)
                    8'hE0:   hello_tx++;
                    8'hE1:   g_s++;
                    8'hE2:   g_m++;
                    8'hE3:   g_l++;
                    default: ;
                endcase
            end
            if (src_valid && src_ready) begin
                hs_cnt++;
                chk(tx_valid && !tx_ctrl && tx_data == src_data, "R4 token passthrough",
                    int'(tx_data), int'(src_data));
            end
            if (snk_valid && snk_ready) begin
                chk(!snk_ctrl && snk_data == sink_seq, "R9 sink order",
                    int'({snk_ctrl, snk_data}), int'(sink_seq));
                sink_seq++;
            end
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", n_cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Vector table: grant code selector, tokens offered, tokens expected through.
    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] n;
        logic [7:0] exp;
    } vec_t;
    localparam vec_t VECS [0:5] = '{
        '{2'd1, 8'd5,  8'd5},
        '{2'd1, 8'd12, 8'd8},
        '{2'd2, 8'd20, 8'd16},
        '{2'd3, 8'd70, 8'd64},
        '{2'd2, 8'd3,  8'd3},
        '{2'd3, 8'd10, 8'd10}
    };

    initial begin
        int got, h0, g0, gs0, gm0, gl0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1); #1;
        chk(!tx_valid, "R1 reset tx_valid", int'(tx_valid), 0);
        chk(!src_ready, "R1 reset src_ready", int'(src_ready), 0);
        chk(!snk_valid, "R9 reset snk_valid", int'(snk_valid), 0);
        link_en = 1'b1;
        cyc(2);

        // R3 R4 R5: each vector restarts with a reset token, so leftovers must vanish
        for (int v = 0; v < 6; v++) begin
            h0 = hello_tx;
            do_hello();
            chk(hello_tx == h0 + 1, "R2 reset token sent", hello_tx - h0, 1);
            send_rx(1'b1, 8'hE0 + 8'(VECS[v].sel));
            cyc(1);
            offer(int'(VECS[v].n), got);
            chk(got == int'(VECS[v].exp), "R3/R4/R5 credited sends", got, int'(VECS[v].exp));
        end

        // R8: data with nothing outstanding is dropped
        send_rx(1'b0, 8'h55);
        cyc(2); #1;
        chk(!snk_valid, "R8 uncredited drop", int'(snk_valid), 0);

        // R3: reset token accepted in the same cycle a grant of 16 arrives
        tx_ready = 1'b0;
        hello_req = 1'b1;
        cyc(1);
        hello_req = 1'b0;
        cyc(2); #1;
        chk(tx_valid && tx_ctrl && tx_data == 8'hE0, "R2 reset token held",
            int'(tx_data), 8'hE0);
        chk(!src_ready, "R10 source blocked by reset", int'(src_ready), 0);
        tx_ready = 1'b1;
        send_rx(1'b1, 8'hE2);
        offer(30, got);
        chk(got == 16, "R3 coincident grant kept", got, 16);

        // R4: send and grant in the same cycle
        send_rx(1'b1, 8'hE1);
        offer(7, got);
        chk(got == 7, "R4 partial spend", got, 7);
        h0 = hs_cnt;
        src_valid = 1'b1; src_data = 8'(hs_cnt);
        send_rx(1'b1, 8'hE1);
        src_valid = 1'b0;
        chk(hs_cnt == h0 + 1, "R4 coincident send", hs_cnt - h0, 1);
        offer(20, got);
        chk(got == 8, "R4 net credit", got, 8);

        // R6 R7 R10: far-end reset produces a 64 grant ahead of source traffic
        send_rx(1'b1, 8'hE1);
        gl0 = g_l;
        rx_valid = 1'b1; rx_ctrl = 1'b1; rx_data = 8'hE0;
        src_valid = 1'b1; src_data = 8'(hs_cnt);
        cyc(1);
        rx_valid = 1'b0; rx_ctrl = 1'b0;
        src_data = 8'(hs_cnt);
        #1;
        chk(tx_valid && tx_ctrl && tx_data == 8'hE3, "R6 grant after far-end reset",
            int'(tx_data), 8'hE3);
        chk(!src_ready, "R10 grant before source", int'(src_ready), 0);
        src_valid = 1'b0;
        cyc(3);
        chk(g_l == gl0 + 1, "R7 one 64 grant", g_l - gl0, 1);

        // R7 R8: fill 60, then drain and watch thresholds
        for (int i = 0; i < 60; i++) begin
            send_rx(1'b0, rx_seq);
            rx_seq++;
        end
        g0 = g_s + g_m + g_l;
        cyc(3);
        chk(g_s + g_m + g_l == g0, "R7 no room no grant", g_s + g_m + g_l - g0, 0);
        chk(snk_valid, "R9 data queued", int'(snk_valid), 1);
        gs0 = g_s;
        snk_ready = 1'b1; cyc(8); snk_ready = 1'b0;
        cyc(3);
        chk(g_s == gs0 + 1, "R7 grant of 8", g_s - gs0, 1);
        g0 = g_s + g_m + g_l;
        snk_ready = 1'b1; cyc(16); snk_ready = 1'b0;
        cyc(3);
        chk(g_s + g_m + g_l == g0, "R7 above low mark", g_s + g_m + g_l - g0, 0);
        gm0 = g_m;
        for (int i = 0; i < 5; i++) begin
            send_rx(1'b0, rx_seq);
            rx_seq++;
        end
        cyc(3);
        chk(g_m == gm0 + 1, "R7 grant of 16", g_m - gm0, 1);
        snk_ready = 1'b1; cyc(50); snk_ready = 1'b0;
        #1;
        chk(sink_seq == 8'd65, "R9 all data delivered", int'(sink_seq), 65);
        chk(!snk_valid, "R9 sink empty", int'(snk_valid), 0);

        // R1 R2: disabled link is quiet and ignores requests and received tokens
        link_en = 1'b0;
        src_valid = 1'b1;
        cyc(1); #1;
        chk(!tx_valid, "R1 disabled tx", int'(tx_valid), 0);
        chk(!src_ready, "R1 disabled src_ready", int'(src_ready), 0);
        src_valid = 1'b0;
        h0 = hello_tx;
        hello_req = 1'b1; cyc(1); hello_req = 1'b0;
        cyc(3);
        chk(hello_tx == h0, "R2 request ignored when off", hello_tx - h0, 0);
        send_rx(1'b1, 8'hE0);
        g0 = g_s + g_m + g_l;
        link_en = 1'b1;
        cyc(4);
        chk(g_s + g_m + g_l == g0, "R1 far-end reset ignored when off",
            g_s + g_m + g_l - g0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule